// File: doc/BRIEF.md
# Ethernet Transmit Statistics Counters

This block holds two transmit statistics counters for an Ethernet MAC: a 32-bit count of bytes placed on the wire and a 22-bit count of frames sent. The transmit path raises a one-cycle completion strobe for every frame it finishes, along with the frame's untruncated byte length and an abort flag. Every completed frame counts as a packet, whatever its outcome. The byte count leaves out preamble, SFD and jam bytes. Bytes of fragments that collided are included in the length the transmit path reports.

In half-duplex back-pressure mode the MAC sends preamble bytes only to hold the medium. These bytes do not belong to any frame. The MAC reports each one with a pulse. The block banks these pulses and adds the banked total to the byte increment of the next completed frame. That combined increment is capped at 65,535. A one-bit select and a write strobe give software read and write access to either counter. Each counter gives a one-cycle carry pulse when it wraps.

Top module: `tx_stat_counters`

## Requirements
- R1: With `reg_sel`=1, `reg_rdata` shows the 22-bit packet count in bits 21:0, and bits 31:22 read zero. A packet write loads `reg_wdata[21:0]`.
- R2: Each `frame_done` strobe adds exactly one to the packet counter. The value of `frame_abort` has no effect on this.
- R3: Each `frame_done` strobe adds `frame_len` plus the banked phantom total to the byte counter. This covers truncated and collided frames, whose length is reported untruncated.
- R4: While `bp_en` is high, each `phantom_byte` pulse adds one to the bank. The bank total goes into the next frame's increment, and the bank then clears.
- R5: A `phantom_byte` pulse in the same cycle as `frame_done` is not part of that frame's increment. It is carried into the following frame.
- R6: While `bp_en` is low, `phantom_byte` pulses are ignored and the bank is held at zero.
- R7: The per-frame byte increment (length plus bank) is capped at 65,535. The bank itself saturates at 65,535.
- R8: Both counters wrap modulo 2^width. `byte_wrap` or `pkt_wrap` is high for exactly the one cycle after the clock edge on which its counter wrapped.
- R9: A software write (`reg_wr` with `reg_sel`=0 for bytes, 1 for packets) has priority over a hardware increment in the same cycle. The written value is loaded, and no carry pulse follows.
- R10: After reset (`rst_n` low, asynchronous), both counters, the bank and both carry outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe when a frame finishes transmitting |
| frame_len | input | 16 | Untruncated on-wire byte count of the frame |
| frame_abort | input | 1 | Frame was aborted or bad (still counted) |
| bp_en | input | 1 | Half-duplex back-pressure mode enable |
| phantom_byte | input | 1 | One pulse per back-pressure preamble byte sent |
| reg_sel | input | 1 | 0 selects the byte counter, 1 selects the packet counter |
| reg_wr | input | 1 | Write strobe for the selected counter |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected counter (combinational) |
| byte_wrap | output | 1 | Byte counter carry pulse |
| pkt_wrap | output | 1 | Packet counter carry pulse |

## Verification
Any error in the bank shows up as a wrong byte count one cycle after the next frame completes. If no frame follows, the error stays hidden. The bench therefore ends phantom runs with frames, including a frame in the same cycle as a pulse. An off-by-one in either counter's carry logic shows as a missing or extra wrap pulse on the edge after the wrap. To reach that edge quickly, the bench writes values just below the wrap point. Because the select input changes every cycle, the bench compares both counters and both carry outputs against its model on almost every clock.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;
    localparam int BYTE_W = 32;
    localparam int PKT_W  = 22;
    localparam int LEN_W  = 16;
    localparam int REG_W  = 32;

    typedef enum logic {
        SEL_BYTES = 1'b0,
        SEL_PKTS  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/tx_stat_phantom.sv
module tx_stat_phantom #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pulse,
    input  logic             take,
    output logic [LEN_W-1:0] acc_o
);
    localparam logic [LEN_W-1:0] ACC_MAX = '1;

    typedef struct packed {
        logic [LEN_W-1:0] acc;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        logic [LEN_W-1:0] base;
        st_d = st_q;
        base = take ? '0 : st_q.acc;
        if (!en) begin
            st_d.acc = '0;
        end else if (pulse && base != ACC_MAX) begin
            st_d.acc = base + 1'b1;
        end else begin
            st_d.acc = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;

    // R5
    carry_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> acc_o <= 1);
    // R6
    bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> acc_o == '0);
endmodule

// File: rtl/tx_stat_incr.sv
module tx_stat_incr #(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] bank,
    output logic [LEN_W-1:0] inc_o
);
    logic [LEN_W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, frame_len} + {1'b0, bank};
        inc_o    = wide_sum[LEN_W] ? '1 : wide_sum[LEN_W-1:0];
    end
endmodule

// File: rtl/tx_stat_ctr.sv
module tx_stat_ctr #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_en,
    input  logic [IW-1:0] inc_val,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_val,
    output logic [W-1:0]  cnt_o,
    output logic          wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         wrap;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        logic [W:0] ext;
        logic [W:0] sum;
        ext          = '0;
        ext[IW-1:0]  = inc_val;
        sum          = {1'b0, st_q.cnt} + ext;
        st_d         = st_q;
        st_d.wrap    = 1'b0;
        if (wr_en) begin
            st_d.cnt = wr_val;
        end else if (inc_en) begin
            st_d.cnt  = sum[W-1:0];
            st_d.wrap = sum[W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = st_q.wrap;

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_o == $past(wr_val)) && !wrap_o);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !inc_en) |=> $stable(cnt_o) && !wrap_o);
    // R8
    wrap_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> cnt_o < $past(cnt_o));
endmodule

// File: rtl/tx_stat_counters.sv
module tx_stat_counters
    import tx_stat_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int PW = PKT_W,
    parameter int LW = LEN_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_done,
    input  logic [LW-1:0] frame_len,
    input  logic          frame_abort,
    input  logic          bp_en,
    input  logic          phantom_byte,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          byte_wrap,
    output logic          pkt_wrap
);
    localparam int PAD_W = RW - PW;

    logic [LW-1:0] bank;
    logic [LW-1:0] byte_inc;
    logic [BW-1:0] byte_cnt;
    logic [PW-1:0] pkt_cnt;
    logic          wr_bytes;
    logic          wr_pkts;

    assign wr_bytes = reg_wr && (reg_sel == SEL_BYTES);
    assign wr_pkts  = reg_wr && (reg_sel == SEL_PKTS);

    tx_stat_phantom #(.LEN_W(LW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (bp_en),
        .pulse (phantom_byte),
        .take  (frame_done),
        .acc_o (bank)
    );

    tx_stat_incr #(.LEN_W(LW)) u_incr (
        .frame_len (frame_len),
        .bank      (bank),
        .inc_o     (byte_inc)
    );

    tx_stat_ctr #(.W(BW), .IW(LW)) u_bytes (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (frame_done),
        .inc_val (byte_inc),
        .wr_en   (wr_bytes),
        .wr_val  (reg_wdata[BW-1:0]),
        .cnt_o   (byte_cnt),
        .wrap_o  (byte_wrap)
    );

    tx_stat_ctr #(.W(PW), .IW(1)) u_pkts (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (frame_done),
        .inc_val (1'b1),
        .wr_en   (wr_pkts),
        .wr_val  (reg_wdata[PW-1:0]),
        .cnt_o   (pkt_cnt),
        .wrap_o  (pkt_wrap)
    );

    always_comb begin
        if (reg_sel == SEL_PKTS) reg_rdata = {{PAD_W{1'b0}}, pkt_cnt};
        else                     reg_rdata = byte_cnt;
    end

    // R2
    abort_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_abort && !wr_pkts) |=> pkt_cnt == $past(pkt_cnt) + 1'b1);
    // R7
    incr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> byte_inc >= frame_len);
    // R4
    incr_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && bank == '0) |-> byte_inc == frame_len);
endmodule

// File: tb/sim_tx_stat_counters.sv
`timescale 1ns/1ps
module sim_tx_stat_counters;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_done = 1'b0;
    logic [15:0] frame_len = '0;
    logic        frame_abort = 1'b0;
    logic        bp_en = 1'b0;
    logic        phantom_byte = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        byte_wrap;
    logic        pkt_wrap;

    int vectors = 0;
    int errors  = 0;

    longint m_bytes = 0;
    longint m_pkts  = 0;
    longint m_bank  = 0;
    bit     m_bw    = 1'b0;
    bit     m_pw    = 1'b0;

    always #10 clk = ~clk;

    tx_stat_counters u0 (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_len(frame_len),
        .frame_abort(frame_abort), .bp_en(bp_en), .phantom_byte(phantom_byte),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .byte_wrap(byte_wrap), .pkt_wrap(pkt_wrap)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        longint inc;
        longint t;
        longint base;
        m_bw = 1'b0;
        m_pw = 1'b0;
        if (reg_wr && !reg_sel) m_bytes = reg_wdata;
        else if (frame_done) begin
            inc = frame_len + m_bank;
            if (inc > 65535) inc = 65535;
            t = m_bytes + inc;
            m_bw = (t >= 64'h1_0000_0000);
            m_bytes = t % 64'h1_0000_0000;
        end
        if (reg_wr && reg_sel) m_pkts = reg_wdata[21:0];
        else if (frame_done) begin
            t = m_pkts + 1;
            m_pw = (t >= (1 << 22));
            m_pkts = t % (1 << 22);
        end
        if (!bp_en) m_bank = 0;
        else begin
            base = frame_done ? 0 : m_bank;
            if (phantom_byte && base < 65535) base++;
            m_bank = base;
        end
    endtask

    task automatic compare();
        if (reg_sel) chk("R1/R2 packet count", reg_rdata, m_pkts);
        else         chk("R3/R4/R7 byte count", reg_rdata, m_bytes);
        chk("R8 byte_wrap", byte_wrap, m_bw);
        chk("R8 pkt_wrap", pkt_wrap, m_pw);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        frame_done = 0; phantom_byte = 0; reg_wr = 0; frame_abort = 0;
    endtask

    task automatic send(input int len, input bit abort);
        idle();
        frame_done = 1; frame_len = 16'(len); frame_abort = abort;
        tick();
        idle();
    endtask

    task automatic swr(input bit sel, input logic [31:0] v);
        idle();
        reg_sel = sel; reg_wr = 1; reg_wdata = v;
        tick();
        idle();
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state, both selections
        reg_sel = 0; #1 chk("R10 reset bytes", reg_rdata, 0);
        reg_sel = 1; #1 chk("R10 reset pkts", reg_rdata, 0);
        chk("R10 reset wraps", {byte_wrap, pkt_wrap}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 R3: plain and aborted frames
        reg_sel = 0; send(64, 0); send(1518, 1);
        reg_sel = 1; tick(); chk("R2 two frames", reg_rdata, 2);

        // R4: bank phantom bytes then a frame
        bp_en = 1;
        for (int i = 0; i < 20; i++) begin phantom_byte = 1; tick(); end
        idle(); reg_sel = 0; send(100, 0); tick();
        chk("R4 banked bytes added", reg_rdata, 64 + 1518 + 120);

        // R5: pulse together with frame goes to the following frame
        for (int i = 0; i < 5; i++) begin phantom_byte = 1; tick(); end
        frame_done = 1; frame_len = 10; phantom_byte = 1; tick(); idle();
        send(10, 0);
        chk("R5 carried pulse", reg_rdata, 1702 + 15 + 11);

        // R6: pulses ignored while disabled
        bp_en = 0;
        for (int i = 0; i < 8; i++) begin phantom_byte = 1; tick(); end
        idle(); send(7, 0);
        chk("R6 pulses ignored", reg_rdata, 1728 + 7);

        // R7: increment cap
        bp_en = 1;
        for (int i = 0; i < 40; i++) begin phantom_byte = 1; tick(); end
        idle(); send(65530, 0);
        chk("R7 capped increment", reg_rdata, 1735 + 65535);

        // R8 R9: byte wrap, write priority
        swr(0, 32'hFFFF_FF00);
        send(300, 0);
        chk("R8 byte wrapped", reg_rdata, 300 - 256);
        chk("R8 byte_wrap high", byte_wrap, 1);
        tick(); chk("R8 byte_wrap one cycle", byte_wrap, 0);
        frame_done = 1; frame_len = 50; reg_wr = 1; reg_sel = 0; reg_wdata = 32'hFFFF_FFFF;
        tick(); idle();
        chk("R9 write beats increment", reg_rdata, 32'hFFFF_FFFF);
        chk("R9 no wrap on write", byte_wrap, 0);

        // R1 R8: packet field, upper bits, wrap
        swr(1, 32'hFFFF_FFFF);
        chk("R1 upper bits zero", reg_rdata, 22'h3F_FFFF);
        send(1, 0);
        chk("R8 pkt wrapped", reg_rdata, 0);
        chk("R8 pkt_wrap high", pkt_wrap, 1);

        // random traffic, all requirements
        for (int i = 0; i < 4000; i++) begin
            frame_done   = ($urandom_range(0, 2) == 0);
            frame_len    = ($urandom_range(0, 9) == 0) ? 16'($urandom_range(65000, 65535))
                                                       : 16'($urandom_range(0, 1600));
            frame_abort  = $urandom_range(0, 1);
            phantom_byte = $urandom_range(0, 1);
            bp_en        = ($urandom_range(0, 7) != 0);
            reg_sel      = $urandom_range(0, 1);
            reg_wr       = ($urandom_range(0, 29) == 0);
            reg_wdata    = ($urandom_range(0, 1) == 1) ? 32'hFFFF_F000 + $urandom_range(0, 4095)
                                                       : $urandom;
            if (reg_sel && reg_wr) reg_wdata[21:0] = 22'h3F_FFF0 + 22'($urandom_range(0, 15));
            tick();
        end
        idle();
        tick();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule